// File: doc/BRIEF.md
# Serial Latch-Programming Port

This block is the write side of a three-wire control port for a programmable clock synthesizer. A host drives a serial clock, a serial data line and a load strobe. Bits are shifted into a 24-bit register on each rising serial clock edge, most significant bit first. When the load strobe rises, the word's two lowest bits choose which of four control latches takes the word: reference divider, feedback divider, function, or initialization.

The decoded latch contents drive the divider and charge-pump logic elsewhere on the chip. The block also emits a single-cycle counter reset pulse. An initialization write fires this pulse and arms a one-shot. The next feedback-divider write fires the pulse again and clears the one-shot. All three host pins are synchronized into the system clock domain and edge-detected there. The port keeps accepting words at all times, including while the synthesizer is powered down.

Top module: `ser_prog_port`

## Requirements
- R1: After a synchronous active-low reset, every latch output is zero and no counter reset pulse is issued.
- R2: Each rising serial clock edge shifts the data bit into bit 0 of a 24-bit register, moving older bits toward bit 23. The first bit sent ends up in bit 23 and bits older than 24 edges are lost.
- R3: A load with word bits 1:0 = 00 updates only the reference outputs: divide value from bits 15:2, backlash width from bits 17:16, test bits from bits 19:18 and lock precision from bit 20.
- R4: A load with bits 1:0 = 01 updates only the feedback outputs: divide value from bits 20:8 and charge-pump gain from bit 21.
- R5: A load with bits 1:0 = 10 updates only the function outputs, with no reset pulse. The fields are: counter hold from bit 2, power-down 1 from bit 3, mux select from bits 6:4, phase polarity from bit 7, pump high-impedance from bit 8, fastlock enable from bit 9, fastlock mode from bit 10, timer from bits 14:11, current 1 from bits 17:15, current 2 from bits 20:18 and power-down 2 from bit 21.
- R6: A load with bits 1:0 = 11 updates the function outputs exactly as R5 does. It also issues one counter reset pulse and arms the one-shot.
- R7: The first feedback load after an initialization load issues a reset pulse and disarms the one-shot. Reference and function loads leave the one-shot as it is. Further feedback loads issue no pulse.
- R8: Latch outputs change only in the system clock cycle after a detected load strobe edge. They stay steady while bits are shifting.
- R9: Each rising load strobe edge causes exactly one load. Holding the strobe high while more bits are shifted causes no further load.
- R10: When a serial clock edge and a load strobe edge are detected in the same cycle, the load takes the word as it was before that bit. The bit still enters the shift register.
- R11: The counter reset pulse lasts exactly one system clock cycle per triggering load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock from host (asynchronous) |
| ser_data_i | input | 1 | Serial data from host |
| ser_load_i | input | 1 | Load strobe from host |
| refdiv_o | output | 14 | Reference divide value |
| abw_o | output | 2 | Anti-backlash width code |
| tmode_o | output | 2 | Test mode bits |
| ldprec_o | output | 1 | Lock detect precision |
| fbdiv_o | output | 13 | Feedback divide value |
| cpgain_o | output | 1 | Charge-pump gain select |
| ctr_hold_o | output | 1 | Counter hold-in-reset |
| pdn1_o | output | 1 | Power-down 1 |
| muxsel_o | output | 3 | Output mux select |
| pfd_pol_o | output | 1 | Phase detector polarity |
| cp_hiz_o | output | 1 | Charge pump high-impedance |
| fl_en_o | output | 1 | Fastlock enable |
| fl_mode_o | output | 1 | Fastlock mode |
| fl_timer_o | output | 4 | Fastlock timer code |
| icp1_o | output | 3 | Charge-pump current setting 1 |
| icp2_o | output | 3 | Charge-pump current setting 2 |
| pdn2_o | output | 1 | Power-down 2 |
| ctr_rst_pulse_o | output | 1 | One-cycle divider/timer counter reset |

## Verification
Shifting and loading can land in the same system clock cycle. This happens when the host raises the serial clock and the load strobe together, so both synchronized edges are detected at once. The bench does this on purpose after a full word. It then checks that the selected latch holds the word from before the coinciding bit. A second strobe edge then loads the shifted word, with that bit now in position 0 and a different latch selected. This shows the bit was not dropped. Random words with random select codes also run through a model of the one-shot reset rule.

// File: rtl/sp_pkg.sv
// Package: shared widths, select codes and decoded latch field types for
// the serial latch-programming port.
package sp_pkg;
    localparam int WORD_W = 24;
    localparam int SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_REF  = 2'b00,
        SEL_FB   = 2'b01,
        SEL_FUNC = 2'b10,
        SEL_INIT = 2'b11
    } sel_e;

    typedef struct packed {
        logic        ldprec;
        logic [1:0]  tmode;
        logic [1:0]  abw;
        logic [13:0] div;
    } ref_fields_t;

    typedef struct packed {
        logic        cpgain;
        logic [12:0] div;
    } fb_fields_t;

    typedef struct packed {
        logic       pdn2;
        logic [2:0] icp2;
        logic [2:0] icp1;
        logic [3:0] timer;
        logic       fl_mode;
        logic       fl_en;
        logic       cp_hiz;
        logic       pol;
        logic [2:0] muxsel;
        logic       pdn1;
        logic       hold;
    } func_fields_t;

    // Extract reference-latch fields from a shifted word.
    function automatic ref_fields_t to_ref(input logic [WORD_W-1:0] w);
        ref_fields_t r;
        r.div    = w[15:2];
        r.abw    = w[17:16];
        r.tmode  = w[19:18];
        r.ldprec = w[20];
        return r;
    endfunction

    // Extract feedback-latch fields from a shifted word.
    function automatic fb_fields_t to_fb(input logic [WORD_W-1:0] w);
        fb_fields_t f;
        f.div    = w[20:8];
        f.cpgain = w[21];
        return f;
    endfunction

    // Extract function-latch fields from a shifted word.
    function automatic func_fields_t to_func(input logic [WORD_W-1:0] w);
        func_fields_t f;
        f.hold    = w[2];
        f.pdn1    = w[3];
        f.muxsel  = w[6:4];
        f.pol     = w[7];
        f.cp_hiz  = w[8];
        f.fl_en   = w[9];
        f.fl_mode = w[10];
        f.timer   = w[14:11];
        f.icp1    = w[17:15];
        f.icp2    = w[20:18];
        f.pdn2    = w[21];
        return f;
    endfunction
endpackage

// File: rtl/sp_edge_sync.sv
// Module: sp_edge_sync
// Synchronizes strobe inputs and level inputs through STAGES flops and
// reports one-cycle rising-edge pulses on the strobes. Level outputs are
// delayed by the same amount as the strobes, so a level bit arrives in the
// same cycle as the strobe edge that came with it.
// Assumes: inputs are held low while reset is asserted.
module sp_edge_sync #(
    parameter int STAGES = 2,
    parameter int EDGE_W = 2,
    parameter int LVL_W  = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [EDGE_W-1:0] edge_i,
    input  logic [LVL_W-1:0]  lvl_i,
    output logic [EDGE_W-1:0] rise_o,
    output logic [LVL_W-1:0]  lvl_o
);
    localparam int TOT_W = EDGE_W + LVL_W;

    logic [TOT_W-1:0]  stg [STAGES];
    logic [EDGE_W-1:0] prev_q;

    // Synchronizer chain for all pins together.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= {lvl_i, edge_i};
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    // Previous synchronized strobe level, used for edge detection.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= stg[STAGES-1][EDGE_W-1:0];
    end

    assign rise_o = stg[STAGES-1][EDGE_W-1:0] & ~prev_q;
    assign lvl_o  = stg[STAGES-1][TOT_W-1:EDGE_W];

    // R9: one strobe edge yields a pulse of a single cycle only.
    for (genvar g = 0; g < EDGE_W; g++) begin : g_edge_chk
        a_r9_single_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
            rise_o[g] |=> !rise_o[g]);
    end
endmodule

// File: rtl/sp_shift.sv
// Module: sp_shift
// Serial-in shift register. It shifts the data bit into bit 0 on each enable,
// so the first bit sent ends in the top position.
module sp_shift #(
    parameter int W = 24
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         sh_en_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);
    logic [W-1:0] sh_q;

    // Shift one bit per detected serial clock edge.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      sh_q <= '0;
        else if (sh_en_i) sh_q <= {sh_q[W-2:0], bit_i};
    end

    assign word_o = sh_q;

    // R2: new bit lands at position 0 and older bits move up by one.
    a_r2_msb_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sh_en_i |=> (word_o[0] == $past(bit_i)) &&
                    (word_o[W-1:1] == $past(word_o[W-2:0])));
endmodule

// File: rtl/sp_latch_bank.sv
// Module: sp_latch_bank
// Holds the reference, feedback and function latches. On a load it routes
// the word by its low select bits. It also runs the one-shot counter reset
// rule: an init load fires the pulse and arms it, and the next feedback load
// fires again and disarms it.
// Assumes: load_i is a single-cycle pulse.
module sp_latch_bank
    import sp_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    output ref_fields_t       ref_o,
    output fb_fields_t        fb_o,
    output func_fields_t      func_o,
    output logic              rst_pulse_o
);
    sel_e         sel;
    ref_fields_t  ref_q;
    fb_fields_t   fb_q;
    func_fields_t func_q;
    logic         armed_q;
    logic         pulse_q;
    logic         fire;

    assign sel  = sel_e'(word_i[SEL_W-1:0]);
    assign fire = load_i && ((sel == SEL_INIT) || ((sel == SEL_FB) && armed_q));

    // Reference latch: written only by select code 00.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                        ref_q <= '0;
        else if (load_i && sel == SEL_REF)  ref_q <= to_ref(word_i);
    end

    // Feedback latch: written only by select code 01.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                       fb_q <= '0;
        else if (load_i && sel == SEL_FB)  fb_q <= to_fb(word_i);
    end

    // Function latch: written by both the function and the init code.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            func_q <= '0;
        else if (load_i && (sel == SEL_FUNC || sel == SEL_INIT))
            func_q <= to_func(word_i);
    end

    // One-shot arm: set by init, cleared by the next feedback load.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                       armed_q <= 1'b0;
        else if (load_i && sel == SEL_INIT) armed_q <= 1'b1;
        else if (load_i && sel == SEL_FB)   armed_q <= 1'b0;
    end

    // Registered counter reset pulse.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) pulse_q <= 1'b0;
        else         pulse_q <= fire;
    end

    assign ref_o       = ref_q;
    assign fb_o        = fb_q;
    assign func_o      = func_q;
    assign rst_pulse_o = pulse_q;

    // R8: no latch moves without a load.
    a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(ref_q) && $stable(fb_q) && $stable(func_q));
    // R3: the reference latch ignores other select codes.
    a_r3_ref_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && word_i[1:0] != 2'b00) |=> $stable(ref_q));
    // R4: the feedback latch ignores other select codes.
    a_r4_fb_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && word_i[1:0] != 2'b01) |=> $stable(fb_q));
    // R6: an init load always pulses and copies the function fields.
    a_r6_init_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && word_i[1:0] == 2'b11) |=> pulse_q && (func_q == $past(to_func(word_i))));
    // R5: a function load never pulses.
    a_r5_func_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && word_i[1:0] == 2'b10) |=> !pulse_q);
    // R7: a feedback load while disarmed does not pulse.
    a_r7_no_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && word_i[1:0] == 2'b01 && !armed_q) |=> !pulse_q);
    // R11: the pulse is one cycle wide.
    a_r11_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_q |=> !pulse_q);
endmodule

// File: rtl/ser_prog_port.sv
// Module: ser_prog_port (top)
// Three-wire serial write port. It synchronizes the host pins, shifts data
// on serial clock edges and loads the selected latch on the load strobe edge.
// Assumes: the host holds the pins low during reset, and each pin level
// lasts longer than SYNC_STAGES+1 system clocks.
module ser_prog_port
    import sp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        ser_clk_i,
    input  logic        ser_data_i,
    input  logic        ser_load_i,
    output logic [13:0] refdiv_o,
    output logic [1:0]  abw_o,
    output logic [1:0]  tmode_o,
    output logic        ldprec_o,
    output logic [12:0] fbdiv_o,
    output logic        cpgain_o,
    output logic        ctr_hold_o,
    output logic        pdn1_o,
    output logic [2:0]  muxsel_o,
    output logic        pfd_pol_o,
    output logic        cp_hiz_o,
    output logic        fl_en_o,
    output logic        fl_mode_o,
    output logic [3:0]  fl_timer_o,
    output logic [2:0]  icp1_o,
    output logic [2:0]  icp2_o,
    output logic        pdn2_o,
    output logic        ctr_rst_pulse_o
);
    logic [1:0]        rise;
    logic [0:0]        data_s;
    logic [WORD_W-1:0] word;
    ref_fields_t       ref_f;
    fb_fields_t        fb_f;
    func_fields_t      func_f;

    sp_edge_sync #(.STAGES(SYNC_STAGES), .EDGE_W(2), .LVL_W(1)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .edge_i ({ser_load_i, ser_clk_i}),
        .lvl_i  (ser_data_i),
        .rise_o (rise),
        .lvl_o  (data_s)
    );

    sp_shift #(.W(WORD_W)) u_shift (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sh_en_i (rise[0]),
        .bit_i   (data_s[0]),
        .word_o  (word)
    );

    sp_latch_bank u_bank (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (rise[1]),
        .word_i      (word),
        .ref_o       (ref_f),
        .fb_o        (fb_f),
        .func_o      (func_f),
        .rst_pulse_o (ctr_rst_pulse_o)
    );

    assign refdiv_o   = ref_f.div;
    assign abw_o      = ref_f.abw;
    assign tmode_o    = ref_f.tmode;
    assign ldprec_o   = ref_f.ldprec;
    assign fbdiv_o    = fb_f.div;
    assign cpgain_o   = fb_f.cpgain;
    assign ctr_hold_o = func_f.hold;
    assign pdn1_o     = func_f.pdn1;
    assign muxsel_o   = func_f.muxsel;
    assign pfd_pol_o  = func_f.pol;
    assign cp_hiz_o   = func_f.cp_hiz;
    assign fl_en_o    = func_f.fl_en;
    assign fl_mode_o  = func_f.fl_mode;
    assign fl_timer_o = func_f.timer;
    assign icp1_o     = func_f.icp1;
    assign icp2_o     = func_f.icp2;
    assign pdn2_o     = func_f.pdn2;

    // R10: on coinciding edges the load sees the word before the shift.
    a_r10_load_before_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise[0] && rise[1] && word[1:0] == 2'b00) |=> (ref_f == $past(to_ref(word))));
endmodule

// File: tb/ser_prog_port_tb.sv
// Bench for ser_prog_port: directed corner cases plus seeded random words,
// checked against a bench-side model of the latches and the one-shot.
module ser_prog_port_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, sdi = 1'b0, sle = 1'b0;

    logic [13:0] refdiv; logic [1:0] abw, tmode; logic ldprec;
    logic [12:0] fbdiv;  logic cpgain;
    logic hold, pdn1, pol, hiz, flen, flmode, pdn2, pulse;
    logic [2:0] mux, icp1, icp2; logic [3:0] timer;

    int checks = 0, fails = 0, pulse_cnt = 0, wide_pulse = 0;
    logic pulse_d = 1'b0;
    bit done = 0;

    logic [23:0] m_ref = '0, m_fb = '0, m_fn = '0;
    bit m_armed = 0;
    int m_pulses = 0;

    always #10 clk = ~clk;

    ser_prog_port dut_i (
        .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sck), .ser_data_i(sdi), .ser_load_i(sle),
        .refdiv_o(refdiv), .abw_o(abw), .tmode_o(tmode), .ldprec_o(ldprec),
        .fbdiv_o(fbdiv), .cpgain_o(cpgain), .ctr_hold_o(hold), .pdn1_o(pdn1),
        .muxsel_o(mux), .pfd_pol_o(pol), .cp_hiz_o(hiz), .fl_en_o(flen),
        .fl_mode_o(flmode), .fl_timer_o(timer), .icp1_o(icp1), .icp2_o(icp2),
        .pdn2_o(pdn2), .ctr_rst_pulse_o(pulse)
    );

    // Pulse monitor at the port: counts pulses and flags any wider than one cycle (R11).
    always @(posedge clk) begin
        if (rst_n && pulse) pulse_cnt <= pulse_cnt + 1;
        if (rst_n && pulse && pulse_d) wide_pulse <= wide_pulse + 1;
        pulse_d <= pulse;
    end

    function automatic logic [18:0] exp_ref(input logic [23:0] w); return w[20:2]; endfunction
    function automatic logic [13:0] exp_fb(input logic [23:0] w);  return w[21:8]; endfunction
    function automatic logic [19:0] exp_fn(input logic [23:0] w);  return w[21:2]; endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        sdi = b; tick(4); sck = 1'b1; tick(4); sck = 1'b0; tick(4);
    endtask

    task automatic shift_word(input logic [23:0] w);
        for (int i = 23; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic strobe();
        sle = 1'b1; tick(6); sle = 1'b0; tick(6);
    endtask

    // Model update for one load of word w.
    task automatic model_load(input logic [23:0] w);
        case (w[1:0])
            2'b00: m_ref = w;
            2'b01: begin m_fb = w; if (m_armed) begin m_pulses++; m_armed = 0; end end
            2'b10: m_fn = w;
            default: begin m_fn = w; m_pulses++; m_armed = 1; end
        endcase
    endtask

    task automatic check_all(input string tag);
        chk({tag, " ref"}, {13'd0, ldprec, tmode, abw, refdiv}, {13'd0, exp_ref(m_ref)});
        chk({tag, " fb"},  {18'd0, cpgain, fbdiv}, {18'd0, exp_fb(m_fb)});
        chk({tag, " fn"},  {12'd0, pdn2, icp2, icp1, timer, flmode, flen, hiz, pol, mux, pdn1, hold},
                           {12'd0, exp_fn(m_fn)});
        chk({tag, " pulses"}, pulse_cnt, m_pulses);
    endtask

    task automatic write(input logic [23:0] w, input string tag);
        shift_word(w); strobe(); model_load(w); check_all(tag);
    endtask

    initial begin
        void'($urandom(32'd7321));
        tick(5); rst_n = 1'b1; tick(3);
        check_all("R1 reset");

        write(24'h15A5A4, "R3 ref load");        // code 00
        write(24'h2AB301, "R4 fb load, unarmed R7");
        write(24'h3C5D52, "R5 func load");
        write(24'h0F0F0F, "R6 init load");
        write(24'h123450, "R7 ref keeps arm");
        write(24'h0ABCDE, "R7 func keeps arm");
        write(24'h300F01, "R7 first fb after init");
        write(24'h1FFF01, "R7 second fb no pulse");
        write(24'hFFFFFF, "R6 init all ones");
        write(24'hFFFFFD, "R4 fb all ones");

        // R2: extra leading bits are dropped; only the last 24 count.
        shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b1);
        write(24'h00AAA8, "R2 overflow bits lost");

        // R8: outputs steady while half a word is shifted in.
        shift_word(24'h000FFF);
        for (int i = 0; i < 12; i++) shift_bit(1'b1);
        check_all("R8 steady while shifting");
        strobe(); model_load(24'hFFFFFF); check_all("R8 load after shift");

        // R9: strobe held high while a word is shifted causes no new load.
        shift_word(24'h111114);
        sle = 1'b1; tick(6);
        model_load(24'h111114);
        shift_word(24'h222220);
        check_all("R9 no load while strobe held");
        sle = 1'b0; tick(6); strobe();
        model_load(24'h222220); check_all("R9 reload on new edge");

        // R10: serial clock and strobe rise together.
        shift_word(24'h2AAAA8);
        sdi = 1'b1; tick(4); sck = 1'b1; sle = 1'b1; tick(6); sck = 1'b0; sle = 1'b0; tick(6);
        model_load(24'h2AAAA8); check_all("R10 coincident load uses old word");
        strobe(); model_load({24'h2AAAA8 << 1} | 24'h1);
        check_all("R10 coincident bit was shifted");

        // Random mix of all select codes.
        for (int k = 0; k < 40; k++) begin
            logic [23:0] w;
            w = 24'($urandom);
            write(w, "R7 random");
        end

        chk("R11 pulse width", wide_pulse, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule